// File: doc/BRIEF.md
# Snooping write-invalidate cache controller

This controller sits between one processor and a shared, atomic snooping bus. It manages a small direct-mapped write-back cache with single-word lines. Each line carries a coherence tag (Invalid, Shared or Exclusive), an address tag and a data word. The controller answers processor loads and stores. When a line must be fetched or upgraded, it requests the bus, evicts a dirty victim and issues a read-miss or write-miss command. It then waits for the fill word.

Every transaction another master places on the bus is looked up against the same arrays. A write miss from elsewhere removes a matching copy. A read miss from elsewhere turns an Exclusive copy into a Shared one. Whenever the local copy is dirty, the controller supplies its data word and tells memory to abandon its own reply. Line states change only after the bus has been won. A request that is waiting for the grant is restarted when a snoop touches the line it targets.

Top module: `snoop_wi_cache`

## Requirements
- R1: After reset every line is Invalid, `bus_req` and `cpu_ack` are low, and the first access to any address produces a bus command.
- R2: A read that finds its address in Shared or Exclusive is acknowledged in the cycle it is presented, with the stored word on `cpu_rdata` and no bus command. A write that finds its address in Exclusive also completes in its first cycle without the bus.
- R3: A read to an Invalid line issues a read miss (`bus_cmd`=1) carrying the request address. It is acknowledged in the cycle `fill_valid` is high, returning `fill_data`, and the line becomes Shared.
- R4: A write to an Invalid line issues a write miss (`bus_cmd`=2). It is acknowledged on `fill_valid`, and the line becomes Exclusive and holds the written word.
- R5: A write to a Shared line is handled as a miss: it issues a write miss and leaves the line Exclusive.
- R6: A miss whose index holds an Exclusive line with a different tag first issues a write-back (`bus_cmd`=3) with the old address and word, then issues its own miss. The line index is the low 2 address bits and the tag is the upper 6 bits.
- R7: A snooped write miss (`snp_cmd`=2) from another master to an address held Shared invalidates the line without asserting `snp_abort`.
- R8: A snooped read miss (`snp_cmd`=1) to an address held Exclusive asserts `snp_abort` in that cycle, drives the line's word on `snp_data`, and leaves the line Shared.
- R9: A snooped write miss to an address held Exclusive asserts `snp_abort`, drives the word on `snp_data`, and leaves the line Invalid.
- R10: While `bus_gnt` is low, no bus command is driven, and no line state changes except through snoops.
- R11: A snoop that hits the target index while a request waits for the grant is applied first. The request is then re-evaluated, so a victim downgraded to Shared is not written back.
- R12: When a snoop and a processor request arrive in the same cycle, the snoop is served first: `cpu_stall` is high and `cpu_ack` is low in that cycle.
- R13: Snooped transactions whose `snp_id` equals the controller's own `MY_ID` leave line states unchanged and never assert `snp_abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held with stable fields until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ack | output | 1 | Request complete |
| cpu_stall | output | 1 | Request held back by a snoop this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ack` on reads |
| bus_req | output | 1 | Bus arbitration request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Address of the driven command |
| bus_data | output | DATA_W | Write-back word |
| fill_valid | input | 1 | Fill word for the outstanding miss is present |
| fill_data | input | DATA_W | Fill word |
| snp_valid | input | 1 | A bus transaction is visible |
| snp_cmd | input | 2 | Command of the observed transaction, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Address of the observed transaction |
| snp_id | input | ID_W | Master that issued the observed transaction |
| snp_abort | output | 1 | Memory must abandon its reply; this cache supplies the data |
| snp_data | output | DATA_W | Word supplied on an abort |

## Verification
Several properties are checked on every cycle: a command only appears under grant, line states stay frozen while a request waits without grant or snoop, a stalled request is never acknowledged, a self-issued snoop never aborts or alters a line, and no line stays Exclusive after supplying data. Only the bench scenarios can show the actual state transitions. These include the exact command sequences for upgrades and dirty evictions, the words returned on hits and fills, and the downgrade or invalidation left by a snoop, which shows up in what the next access issues. The restart case, where a downgrade during arbitration removes a write-back, likewise needs a scenario with the grant withheld.

// File: rtl/snoop_wi_cache.sv
module snoop_wi_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic              cpu_stall,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ID_W-1:0]   snp_id,
  output logic              snp_abort,
  output logic [DATA_W-1:0] snp_data
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] L_I = 2'd0, L_S = 2'd1, L_E = 2'd2;
  localparam logic [1:0] C_NONE = 2'd0, C_RD = 2'd1, C_WR = 2'd2, C_WB = 2'd3;

  typedef enum logic [2:0] {F_IDLE, F_ARB, F_WB, F_MISS, F_FILL} fsm_t;
  fsm_t fsm;

  logic [LINES-1:0][1:0] st;
  logic [TAG_W-1:0]      tag_q [LINES];
  logic [DATA_W-1:0]     dat_q [LINES];

  logic              p_we;
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] p_wdata;

  wire [IDX_W-1:0] c_idx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] c_tag = cpu_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] p_idx = p_addr[IDX_W-1:0];
  wire [TAG_W-1:0] p_tag = p_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] s_idx = snp_addr[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag = snp_addr[ADDR_W-1:IDX_W];

  wire snp_act  = snp_valid && (snp_id != ID_W'(MY_ID));
  wire s_hit    = snp_act && st[s_idx] != L_I && tag_q[s_idx] == s_tag;
  wire s_dirty  = s_hit && st[s_idx] == L_E;
  wire c_pres   = st[c_idx] != L_I && tag_q[c_idx] == c_tag;
  wire c_hit    = c_pres && (!cpu_we || st[c_idx] == L_E);
  wire hit_ack  = fsm == F_IDLE && cpu_req && !snp_act && c_hit;
  wire fill_ack = fsm == F_FILL && fill_valid;
  wire restart  = fsm == F_ARB && s_hit && s_idx == p_idx;
  wire victim   = st[p_idx] == L_E && tag_q[p_idx] != p_tag;

  assign cpu_stall = cpu_req && snp_act;
  assign cpu_ack   = hit_ack || fill_ack;
  assign cpu_rdata = fill_ack ? fill_data : dat_q[c_idx];
  assign snp_abort = s_dirty && (snp_cmd == C_RD || snp_cmd == C_WR);
  assign snp_data  = dat_q[s_idx];
  assign bus_req   = fsm != F_IDLE;
  assign bus_cmd   = fsm == F_WB ? C_WB : fsm == F_MISS ? (p_we ? C_WR : C_RD) : C_NONE;
  assign bus_addr  = fsm == F_WB ? {tag_q[p_idx], p_idx} : fsm == F_MISS ? p_addr : '0;
  assign bus_data  = fsm == F_WB ? dat_q[p_idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm     <= F_IDLE;
      p_we    <= 1'b0;
      p_addr  <= '0;
      p_wdata <= '0;
    end else begin
      case (fsm)
        F_IDLE: if (cpu_req && !snp_act && !c_hit) begin
          fsm     <= F_ARB;
          p_we    <= cpu_we;
          p_addr  <= cpu_addr;
          p_wdata <= cpu_wdata;
        end
        F_ARB: begin
          if (restart) fsm <= F_IDLE;
          else if (bus_gnt && !snp_act) fsm <= victim ? F_WB : F_MISS;
        end
        F_WB:   fsm <= F_MISS;
        F_MISS: fsm <= F_FILL;
        F_FILL: if (fill_valid) fsm <= F_IDLE;
        default: fsm <= F_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      if (s_hit) begin
        if (snp_cmd == C_WR) st[s_idx] <= L_I;
        else if (snp_cmd == C_RD && st[s_idx] == L_E) st[s_idx] <= L_S;
      end
      if (hit_ack && cpu_we) dat_q[c_idx] <= cpu_wdata;
      if (fsm == F_WB) st[p_idx] <= L_I;
      if (fill_ack) begin
        tag_q[p_idx] <= p_tag;
        st[p_idx]    <= p_we ? L_E : L_S;
        dat_q[p_idx] <= p_we ? p_wdata : fill_data;
      end
    end
  end

  a_r10_cmd_needs_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != C_NONE) |-> bus_gnt);
  a_r10_lines_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm == F_ARB && !snp_act && !bus_gnt) |=> $stable(st));
  a_r12_stall_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> !cpu_ack);
  a_r13_own_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_id == ID_W'(MY_ID)) |-> !snp_abort);
  a_r13_own_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_id == ID_W'(MY_ID) && (fsm == F_IDLE || fsm == F_ARB)) |=> $stable(st));
  a_r9_supplier_not_excl: assert property (@(posedge clk) disable iff (!rst_n)
    snp_abort |=> st[$past(s_idx)] != L_E);
  a_r3_ack_waits_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm == F_FILL && !fill_valid) |-> !cpu_ack);
endmodule

// File: tb/snoop_wi_cache_bench.sv
module snoop_wi_cache_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0;
  logic [7:0] cpu_addr = 0;
  logic [15:0] cpu_wdata = 0;
  logic cpu_ack, cpu_stall;
  logic [15:0] cpu_rdata;
  logic bus_req;
  logic bus_gnt = 0;
  logic [1:0] bus_cmd;
  logic [7:0] bus_addr;
  logic [15:0] bus_data;
  logic fill_valid = 0;
  logic [15:0] fill_data = 0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = 0;
  logic [7:0] snp_addr = 0;
  logic [1:0] snp_id = 0;
  logic snp_abort;
  logic [15:0] snp_data;

  snoop_wi_cache u_snoop_wi_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_stall(cpu_stall), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_data(bus_data), .fill_valid(fill_valid), .fill_data(fill_data),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_id(snp_id),
    .snp_abort(snp_abort), .snp_data(snp_data));

  int checks = 0, fails = 0;
  logic [15:0] mem [256];
  int m_st [4], m_tag [4], m_dat [4];
  logic [25:0] bus_log [$];
  logic [25:0] exp_q [$];
  bit allow_gnt = 1;
  int fill_cnt = 0;
  logic [7:0] fill_addr = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (fill_cnt == 1) begin
      fill_valid = 1;
      fill_data = mem[fill_addr];
    end else fill_valid = 0;
    if (fill_cnt > 0) fill_cnt--;
    if (rst_n && bus_cmd != 2'd0) begin
      chk(bus_gnt, "R10", "command without grant", int'(bus_cmd), 0);
      if (bus_cmd == 2'd3) begin
        bus_log.push_back({bus_cmd, bus_addr, bus_data});
        mem[bus_addr] = bus_data;
      end else begin
        bus_log.push_back({bus_cmd, bus_addr, 16'd0});
        fill_cnt = 2;
        fill_addr = bus_addr;
      end
    end
    bus_gnt = bus_req && allow_gnt;
  end

  task automatic cpu_op(input bit we, input logic [7:0] a, input logic [15:0] wd,
                        input int extra, input string req);
    int cyc = 0;
    int idx, tg;
    bit hit;
    logic [15:0] rd = 0, erd;
    bus_log.delete();
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    forever begin
      @(negedge clk); #5;
      cyc++;
      if (cpu_ack) begin rd = cpu_rdata; break; end
      if (cyc > 300) break;
    end
    @(posedge clk); #1;
    cpu_req = 0;
    idx = a % 4; tg = a / 4;
    hit = m_st[idx] != 0 && m_tag[idx] == tg && (!we || m_st[idx] == 2);
    exp_q.delete();
    if (!hit) begin
      if (m_st[idx] == 2 && m_tag[idx] != tg)
        exp_q.push_back({2'd3, 8'(m_tag[idx] * 4 + idx), 16'(m_dat[idx])});
      exp_q.push_back({we ? 2'd2 : 2'd1, a, 16'd0});
    end
    erd = hit ? 16'(m_dat[idx]) : mem[a];
    if (hit) begin
      if (we) m_dat[idx] = wd;
    end else begin
      m_tag[idx] = tg; m_st[idx] = we ? 2 : 1; m_dat[idx] = we ? wd : mem[a];
    end
    if (hit) chk(cyc == 1 + extra, req, "hit ack cycle", cyc, 1 + extra);
    else chk(cyc > 1 && cyc <= 300, req, "miss ack cycle", cyc, 5);
    if (!we) chk(rd == erd, req, "read data", rd, erd);
    chk(bus_log.size() == exp_q.size(), req, "bus command count", bus_log.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < bus_log.size(); i++)
      chk(bus_log[i] == exp_q[i], req, "bus command", bus_log[i], exp_q[i]);
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [7:0] a, input logic [1:0] id,
                       input string req);
    int idx, tg;
    bit hitl, dirty, eab;
    @(negedge clk);
    snp_valid = 1; snp_cmd = cmd; snp_addr = a; snp_id = id;
    #5;
    idx = a % 4; tg = a / 4;
    hitl = id != 0 && m_st[idx] != 0 && m_tag[idx] == tg;
    dirty = hitl && m_st[idx] == 2;
    eab = dirty && (cmd == 2'd1 || cmd == 2'd2);
    chk(snp_abort == eab, req, "snoop abort", snp_abort, eab);
    if (eab) chk(snp_data == 16'(m_dat[idx]), req, "snoop data", snp_data, m_dat[idx]);
    if (cpu_req) begin
      chk(cpu_stall == 1, "R12", "stall with snoop", cpu_stall, 1);
      chk(cpu_ack == 0, "R12", "ack under snoop", cpu_ack, 0);
    end
    if (hitl) begin
      if (cmd == 2'd2) m_st[idx] = 0;
      else if (cmd == 2'd1 && m_st[idx] == 2) m_st[idx] = 1;
    end
    @(negedge clk);
    snp_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 37 + 5);
    for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk(bus_req == 0, "R1", "bus_req in reset", bus_req, 0);
    chk(cpu_ack == 0, "R1", "cpu_ack in reset", cpu_ack, 0);
    rst_n = 1;
    cpu_op(0, 8'h10, 0, 0, "R1");
    cpu_op(0, 8'h10, 0, 0, "R2");
    cpu_op(1, 8'h10, 16'hA1A1, 0, "R5");
    cpu_op(1, 8'h10, 16'hA2A2, 0, "R2");
    cpu_op(1, 8'h21, 16'hB1B1, 0, "R4");
    cpu_op(0, 8'h21, 0, 0, "R4");
    cpu_op(0, 8'h30, 0, 0, "R6");
    cpu_op(0, 8'h07, 0, 0, "R3");
    cpu_op(1, 8'h12, 16'hC3C3, 0, "R4");
    snoop(2'd1, 8'h12, 2'd2, "R8");
    cpu_op(0, 8'h12, 0, 0, "R8");
    cpu_op(1, 8'h12, 16'hC4C4, 0, "R8");
    snoop(2'd2, 8'h12, 2'd3, "R9");
    cpu_op(0, 8'h12, 0, 0, "R9");
    snoop(2'd2, 8'h30, 2'd2, "R7");
    cpu_op(0, 8'h30, 0, 0, "R7");
    cpu_op(1, 8'h23, 16'hD5D5, 0, "R4");
    snoop(2'd2, 8'h23, 2'd0, "R13");
    cpu_op(1, 8'h23, 16'hD6D6, 0, "R13");
    fork
      cpu_op(0, 8'h23, 0, 1, "R12");
      snoop(2'd1, 8'h31, 2'd2, "R12");
    join
    allow_gnt = 0;
    fork
      cpu_op(1, 8'h25, 16'hE7E7, 0, "R11");
      begin
        repeat (4) @(posedge clk);
        #1;
        chk(bus_req == 1, "R10", "waiting request", bus_req, 1);
        chk(bus_cmd == 0, "R10", "command before grant", bus_cmd, 0);
        snoop(2'd1, 8'h21, 2'd2, "R11");
        @(posedge clk); #1;
        allow_gnt = 1;
      end
    join
    cpu_op(1, 8'h27, 16'hF8F8, 0, "R6");
    cpu_op(0, 8'h25, 0, 0, "R2");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule